// File: doc/BRIEF.md
# Interrupt Source Pending Aggregator

This block keeps per-source interrupt state for a fixed number of sources and folds it into one request line for the processor. Every source has a level input, a stack of enable conditions modelled as a small counter, a configured target count and a 16-bit vector code. A source is enabled only while its counter sits exactly on its target. It is pending while its level is high and it is enabled.

A neighbouring register block sends single-step enable adjustments (up or down by one) on a sideband port. It also loads each source's target and vector through a configuration port. The block keeps a running tally of pending sources and holds the processor request high while that tally is nonzero. A combinational lookup returns the vector of the lowest-numbered pending source that has a nonzero vector, together with a valid flag.

Top module: `intc_pend_agg`

## Requirements
- R1: After reset every source has count 0, target 1 and vector 0. `irq_req`, `pend_count` and `vec_valid` are 0, and `vec_code` is 0.
- R2: A source is enabled exactly when its counter equals its target. A configuration write (`cfg_we`, `cfg_idx`) loads the target from `cfg_max` and the vector from `cfg_vec`, and clears the counter to 0. A target of 0 therefore enables the source at once.
- R3: An adjustment (`adj_valid`, `adj_idx`) changes the counter by exactly one: up when `adj_up`=1, down when `adj_up`=0. A decrement is applied even when the counter equals the target. The counter holds at 0 on a decrement and holds at its all-ones value on an increment.
- R4: A source is pending when its level is 1 and it is enabled. The pending state is evaluated from the post-adjustment and post-configuration values and is visible after the same clock edge. Holding a level at the same value has no effect.
- R5: `pend_count` equals the number of pending sources after every edge, including edges where several sources change in opposite directions at once.
- R6: `irq_req` is 1 exactly when `pend_count` is nonzero. It rises on the edge where the tally leaves 0 and falls on the edge where it returns to 0.
- R7: The lookup scans sources from index 0 upward. It returns `vec_valid`=1 and the vector of the first pending source in the same cycle. When no source qualifies it returns `vec_valid`=0 and `vec_code`=0.
- R8: A pending source whose vector is 0 is counted in `pend_count` and raises `irq_req`, but the lookup never selects it.
- R9: If a configuration write and an adjustment target the same source in the same cycle, the configuration write takes effect and the adjustment is dropped.
- R10: A configuration write or adjustment whose index is not below the source count changes no source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_level | input | NUM_SRC | Level input per source |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | IDX_W | Source index for configuration |
| cfg_max | input | CNT_W | Enable target to load |
| cfg_vec | input | VEC_W | Vector code to load |
| adj_valid | input | 1 | Enable adjustment strobe |
| adj_idx | input | IDX_W | Source index for adjustment |
| adj_up | input | 1 | 1 = increment, 0 = decrement |
| irq_req | output | 1 | Processor interrupt request |
| pend_count | output | PC_W | Number of pending sources |
| vec_valid | output | 1 | Lookup found a source |
| vec_code | output | VEC_W | Vector of the selected source |

## Verification
The hardest situation to reach from the ports is an enable counter at one of its limits. Reaching the top limit needs a source configured with the all-ones target and a run of seven increments before an eighth one tests the hold. Reaching the bottom limit needs a decrement on a counter at 0 on a source whose level is already high. In both cases a wrap would only show later, as a missing or unexpected change of the pending tally. The stimulus therefore drives those sequences, then makes one more adjustment that exposes the counter's value through `pend_count`. A same-edge collision of a configuration write and an adjustment, and a simultaneous drop of several levels, are also driven.

// File: rtl/intc_agg_pkg.sv
package intc_agg_pkg;

   typedef enum logic {
      ADJ_DOWN = 1'b0,
      ADJ_UP   = 1'b1
   } adj_dir_e;

   localparam int unsigned VEC_W_DEFAULT = 16;

endpackage

// File: rtl/intc_src_slot.sv
module intc_src_slot
   import intc_agg_pkg::*;
#(
   parameter int unsigned CNT_W = 3,
   parameter int unsigned VEC_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             level_i,
   input  logic             cfg_hit_i,
   input  logic [CNT_W-1:0] cfg_max_i,
   input  logic [VEC_W-1:0] cfg_vec_i,
   input  logic             adj_hit_i,
   input  adj_dir_e         adj_dir_i,
   output logic             pend_d_o,
   output logic             pend_q_o,
   output logic [VEC_W-1:0] vec_o
);

   localparam logic [CNT_W-1:0] CNT_TOP   = '1;
   localparam logic [CNT_W-1:0] CNT_ZERO  = '0;
   localparam logic [CNT_W-1:0] CNT_ONE   = CNT_W'(1);
   localparam logic [CNT_W-1:0] MAX_RESET = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic [CNT_W-1:0] max_q, max_d;
   logic [VEC_W-1:0] vec_q, vec_d;
   logic             lvl_q;
   logic             pend_q;

   always_comb begin
      cnt_d = cnt_q;
      max_d = max_q;
      vec_d = vec_q;
      if (cfg_hit_i) begin
         max_d = cfg_max_i;
         vec_d = cfg_vec_i;
         cnt_d = CNT_ZERO;
      end else if (adj_hit_i) begin
         if (adj_dir_i == ADJ_UP) begin
            if (cnt_q != CNT_TOP) cnt_d = cnt_q + CNT_ONE;
         end else begin
            if (cnt_q != CNT_ZERO) cnt_d = cnt_q - CNT_ONE;
         end
      end
   end

   assign pend_d_o = level_i && (cnt_d == max_d);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= CNT_ZERO;
         max_q  <= MAX_RESET;
         vec_q  <= '0;
         lvl_q  <= 1'b0;
         pend_q <= 1'b0;
      end else begin
         cnt_q  <= cnt_d;
         max_q  <= max_d;
         vec_q  <= vec_d;
         lvl_q  <= level_i;
         pend_q <= pend_d_o;
      end
   end

   assign pend_q_o = pend_q;
   assign vec_o    = vec_q;

   assert_pend_needs_level_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      pend_q |-> lvl_q);

   assert_pend_needs_enable_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      pend_q |-> (cnt_q == max_q));

   assert_cfg_clears_count_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      cfg_hit_i |=> (cnt_q == CNT_ZERO));

   assert_single_step_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_hit_i |=> (cnt_q == $past(cnt_q) ||
                      cnt_q == $past(cnt_q) + CNT_ONE ||
                      cnt_q == $past(cnt_q) - CNT_ONE));

   assert_dec_at_target_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      (adj_hit_i && !cfg_hit_i && adj_dir_i == ADJ_DOWN &&
       cnt_q == max_q && cnt_q != CNT_ZERO) |=> !pend_q);

endmodule

// File: rtl/intc_pend_tally.sv
module intc_pend_tally #(
   parameter int unsigned NUM_SRC = 6,
   parameter int unsigned PC_W    = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] pend_d_i,
   input  logic [NUM_SRC-1:0] pend_q_i,
   output logic [PC_W-1:0]    count_o,
   output logic               irq_o
);

   logic [NUM_SRC-1:0] rise, fall;
   logic [PC_W-1:0]    n_rise, n_fall;
   logic [PC_W-1:0]    cnt_q, cnt_d;
   logic               irq_q;

   assign rise = pend_d_i & ~pend_q_i;
   assign fall = ~pend_d_i & pend_q_i;

   always_comb begin
      n_rise = '0;
      n_fall = '0;
      for (int i = 0; i < int'(NUM_SRC); i++) begin
         n_rise = n_rise + PC_W'(rise[i]);
         n_fall = n_fall + PC_W'(fall[i]);
      end
      cnt_d = cnt_q + n_rise - n_fall;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         irq_q <= 1'b0;
      end else begin
         cnt_q <= cnt_d;
         irq_q <= (cnt_d != '0);
      end
   end

   assign count_o = cnt_q;
   assign irq_o   = irq_q;

   assert_tally_matches_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q == PC_W'($countones(pend_q_i)));

   assert_irq_follows_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      irq_q == (cnt_q != '0));

   assert_no_overflow_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      int'(cnt_q) <= int'(NUM_SRC));

endmodule

// File: rtl/intc_vec_pick.sv
module intc_vec_pick #(
   parameter int unsigned NUM_SRC = 6,
   parameter int unsigned VEC_W   = 16
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NUM_SRC-1:0]       pend_i,
   input  logic [NUM_SRC*VEC_W-1:0] vecs_i,
   output logic                     valid_o,
   output logic [VEC_W-1:0]         vec_o
);

   logic [NUM_SRC-1:0] cand;
   logic [NUM_SRC-1:0] grant;

   for (genvar g = 0; g < NUM_SRC; g++) begin : g_cand
      assign cand[g] = pend_i[g] && (vecs_i[g*VEC_W +: VEC_W] != '0);
   end

   always_comb begin
      grant   = '0;
      valid_o = 1'b0;
      vec_o   = '0;
      for (int i = 0; i < int'(NUM_SRC); i++) begin
         if (!valid_o && cand[i]) begin
            grant[i] = 1'b1;
            valid_o  = 1'b1;
            vec_o    = vecs_i[i*VEC_W +: VEC_W];
         end
      end
   end

   assert_single_grant_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant));

   assert_zero_vec_skipped_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> (vec_o != '0));

   assert_idle_lookup_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      (pend_i == '0) |-> (!valid_o && vec_o == '0));

endmodule

// File: rtl/intc_pend_agg.sv
module intc_pend_agg
   import intc_agg_pkg::*;
#(
   parameter int unsigned NUM_SRC = 6,
   parameter int unsigned CNT_W   = 3,
   parameter int unsigned VEC_W   = VEC_W_DEFAULT,
   localparam int unsigned IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
   localparam int unsigned PC_W   = $clog2(NUM_SRC + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_level,
   input  logic               cfg_we,
   input  logic [IDX_W-1:0]   cfg_idx,
   input  logic [CNT_W-1:0]   cfg_max,
   input  logic [VEC_W-1:0]   cfg_vec,
   input  logic               adj_valid,
   input  logic [IDX_W-1:0]   adj_idx,
   input  logic               adj_up,
   output logic               irq_req,
   output logic [PC_W-1:0]    pend_count,
   output logic               vec_valid,
   output logic [VEC_W-1:0]   vec_code
);

   if (NUM_SRC < 1) begin : g_bad_num
      $error("intc_pend_agg: NUM_SRC must be at least 1");
   end
   if (CNT_W < 1 || CNT_W > 8) begin : g_bad_cnt
      $error("intc_pend_agg: CNT_W must lie in 1..8");
   end
   if (VEC_W < 1) begin : g_bad_vec
      $error("intc_pend_agg: VEC_W must be at least 1");
   end

   logic [NUM_SRC-1:0]       pend_d, pend_q;
   logic [NUM_SRC*VEC_W-1:0] vec_flat;
   adj_dir_e                 adj_dir;

   assign adj_dir = adj_dir_e'(adj_up);

   for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
      logic cfg_hit, adj_hit;
      assign cfg_hit = cfg_we    && (cfg_idx == IDX_W'(s));
      assign adj_hit = adj_valid && (adj_idx == IDX_W'(s));

      intc_src_slot #(
         .CNT_W (CNT_W),
         .VEC_W (VEC_W)
      ) u_slot (
         .clk       (clk),
         .rst_n     (rst_n),
         .level_i   (src_level[s]),
         .cfg_hit_i (cfg_hit),
         .cfg_max_i (cfg_max),
         .cfg_vec_i (cfg_vec),
         .adj_hit_i (adj_hit),
         .adj_dir_i (adj_dir),
         .pend_d_o  (pend_d[s]),
         .pend_q_o  (pend_q[s]),
         .vec_o     (vec_flat[s*VEC_W +: VEC_W])
      );
   end

   intc_pend_tally #(
      .NUM_SRC (NUM_SRC),
      .PC_W    (PC_W)
   ) u_tally (
      .clk      (clk),
      .rst_n    (rst_n),
      .pend_d_i (pend_d),
      .pend_q_i (pend_q),
      .count_o  (pend_count),
      .irq_o    (irq_req)
   );

   intc_vec_pick #(
      .NUM_SRC (NUM_SRC),
      .VEC_W   (VEC_W)
   ) u_pick (
      .clk     (clk),
      .rst_n   (rst_n),
      .pend_i  (pend_q),
      .vecs_i  (vec_flat),
      .valid_o (vec_valid),
      .vec_o   (vec_code)
   );

   assert_irq_rises_with_tally_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_req) |-> (pend_count != '0 && $past(pend_count) == '0));

   assert_out_of_range_inert_R10 : assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_we && (!adj_valid || int'(adj_idx) >= int'(NUM_SRC)) && $stable(src_level))
         |=> $stable(pend_count));

endmodule

// File: tb/intc_pend_agg_tb.sv
module intc_pend_agg_tb;

   localparam time CLK_PERIOD = 10ns;
   localparam int  NS   = 6;
   localparam int  CW   = 3;
   localparam int  VW   = 16;
   localparam int  IW   = 3;
   localparam int  PW   = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NS-1:0] src_level = '0;
   logic          cfg_we = 1'b0;
   logic [IW-1:0] cfg_idx = '0;
   logic [CW-1:0] cfg_max = '0;
   logic [VW-1:0] cfg_vec = '0;
   logic          adj_valid = 1'b0;
   logic [IW-1:0] adj_idx = '0;
   logic          adj_up = 1'b0;
   logic          irq_req;
   logic [PW-1:0] pend_count;
   logic          vec_valid;
   logic [VW-1:0] vec_code;

   int n_checks = 0;
   int n_fail   = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   intc_pend_agg #(.NUM_SRC(NS), .CNT_W(CW), .VEC_W(VW)) u_dut (
      .clk(clk), .rst_n(rst_n), .src_level(src_level),
      .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_max(cfg_max), .cfg_vec(cfg_vec),
      .adj_valid(adj_valid), .adj_idx(adj_idx), .adj_up(adj_up),
      .irq_req(irq_req), .pend_count(pend_count),
      .vec_valid(vec_valid), .vec_code(vec_code)
   );

   // kind: 0 idle, 1 configure, 2 adjust
   typedef struct packed {
      logic [1:0]    kind;
      logic [IW-1:0] idx;
      logic          up;
      logic [CW-1:0] max;
      logic [VW-1:0] vec;
      logic [NS-1:0] lvl;
      logic [PW-1:0] e_cnt;
      logic          e_irq;
      logic          e_vv;
      logic [VW-1:0] e_vec;
   } step_t;

   localparam int NSTEP = 14;
   localparam step_t TABLE [NSTEP] = '{
      '{2'd1, 3'd0, 1'b0, 3'd1, 16'h0100, 6'b000000, 3'd0, 1'b0, 1'b0, 16'h0000}, // R2 cfg src0
      '{2'd1, 3'd2, 1'b0, 3'd2, 16'h0300, 6'b000000, 3'd0, 1'b0, 1'b0, 16'h0000}, // R2 cfg src2
      '{2'd1, 3'd4, 1'b0, 3'd0, 16'h0000, 6'b000000, 3'd0, 1'b0, 1'b0, 16'h0000}, // R2 target 0
      '{2'd0, 3'd0, 1'b0, 3'd0, 16'h0000, 6'b000001, 3'd0, 1'b0, 1'b0, 16'h0000}, // R4 not enabled
      '{2'd2, 3'd0, 1'b1, 3'd0, 16'h0000, 6'b000001, 3'd1, 1'b1, 1'b1, 16'h0100}, // R6 0->1
      '{2'd0, 3'd0, 1'b0, 3'd0, 16'h0000, 6'b010001, 3'd2, 1'b1, 1'b1, 16'h0100}, // R8 vec0 counted
      '{2'd2, 3'd0, 1'b0, 3'd0, 16'h0000, 6'b010001, 3'd1, 1'b1, 1'b0, 16'h0000}, // R3 dec at target
      '{2'd0, 3'd0, 1'b0, 3'd0, 16'h0000, 6'b010101, 3'd1, 1'b1, 1'b0, 16'h0000}, // R4
      '{2'd2, 3'd2, 1'b1, 3'd0, 16'h0000, 6'b010101, 3'd1, 1'b1, 1'b0, 16'h0000}, // R2 1 of 2
      '{2'd2, 3'd2, 1'b1, 3'd0, 16'h0000, 6'b010101, 3'd2, 1'b1, 1'b1, 16'h0300}, // R2 2 of 2
      '{2'd2, 3'd0, 1'b1, 3'd0, 16'h0000, 6'b010101, 3'd3, 1'b1, 1'b1, 16'h0100}, // R7 lowest index
      '{2'd0, 3'd0, 1'b0, 3'd0, 16'h0000, 6'b000000, 3'd0, 1'b0, 1'b0, 16'h0000}, // R5 multi fall
      '{2'd2, 3'd7, 1'b1, 3'd0, 16'h0000, 6'b000101, 3'd2, 1'b1, 1'b1, 16'h0100}, // R10 + R5 multi rise
      '{2'd0, 3'd0, 1'b0, 3'd0, 16'h0000, 6'b000101, 3'd2, 1'b1, 1'b1, 16'h0100}  // R4 repeat level
   };

   task automatic check(input logic [PW-1:0] e_cnt, input logic e_irq,
                        input logic e_vv, input logic [VW-1:0] e_vec,
                        input string req);
      n_checks++;
      if (pend_count !== e_cnt || irq_req !== e_irq ||
          vec_valid !== e_vv || vec_code !== e_vec) begin
         n_fail++;
         $display("FAIL %s: cnt=%0d irq=%0b vv=%0b vec=%h expected cnt=%0d irq=%0b vv=%0b vec=%h",
                  req, pend_count, irq_req, vec_valid, vec_code,
                  e_cnt, e_irq, e_vv, e_vec);
      end
   endtask

   task automatic drive(input logic [1:0] kind, input logic [IW-1:0] idx,
                        input logic up, input logic [CW-1:0] mx,
                        input logic [VW-1:0] vc, input logic [NS-1:0] lvl);
      @(negedge clk);
      src_level = lvl;
      cfg_we    = (kind == 2'd1);
      adj_valid = (kind == 2'd2);
      cfg_idx   = idx;  adj_idx = idx;
      adj_up    = up;   cfg_max = mx;  cfg_vec = vc;
      @(posedge clk);
      #1;
      cfg_we    = 1'b0;
      adj_valid = 1'b0;
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      check(3'd0, 1'b0, 1'b0, 16'h0, "R1 in reset");
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk);
      #1;
      check(3'd0, 1'b0, 1'b0, 16'h0, "R1 after reset");

      for (int i = 0; i < NSTEP; i++) begin
         drive(TABLE[i].kind, TABLE[i].idx, TABLE[i].up, TABLE[i].max,
               TABLE[i].vec, TABLE[i].lvl);
         check(TABLE[i].e_cnt, TABLE[i].e_irq, TABLE[i].e_vv, TABLE[i].e_vec,
               $sformatf("table step %0d", i));
      end

      // R3 floor: src1 still at reset target 1, count 0; decrement must hold at 0
      drive(2'd0, 3'd0, 1'b0, 3'd0, 16'h0, 6'b000111);
      check(3'd2, 1'b1, 1'b1, 16'h0100, "R3 src1 level, not enabled");
      drive(2'd2, 3'd1, 1'b0, 3'd0, 16'h0, 6'b000111);
      check(3'd2, 1'b1, 1'b1, 16'h0100, "R3 decrement held at zero");
      drive(2'd2, 3'd1, 1'b1, 3'd0, 16'h0, 6'b000111);
      check(3'd3, 1'b1, 1'b1, 16'h0100, "R3 one up reaches target after floor");

      // R3 ceiling: src3 target 7
      drive(2'd1, 3'd3, 1'b0, 3'd7, 16'h0400, 6'b001111);
      check(3'd3, 1'b1, 1'b1, 16'h0100, "R2 cfg src3 target 7");
      for (int k = 0; k < 6; k++) drive(2'd2, 3'd3, 1'b1, 3'd0, 16'h0, 6'b001111);
      check(3'd3, 1'b1, 1'b1, 16'h0100, "R3 six ups below target");
      drive(2'd2, 3'd3, 1'b1, 3'd0, 16'h0, 6'b001111);
      check(3'd4, 1'b1, 1'b1, 16'h0100, "R3 seventh up reaches top");
      drive(2'd2, 3'd3, 1'b1, 3'd0, 16'h0, 6'b001111);
      check(3'd4, 1'b1, 1'b1, 16'h0100, "R3 up held at all-ones");
      drive(2'd2, 3'd3, 1'b0, 3'd0, 16'h0, 6'b001111);
      check(3'd3, 1'b1, 1'b1, 16'h0100, "R3 down from top");

      // R9: configure and adjust src0 together; config wins, count cleared
      @(negedge clk);
      cfg_we = 1'b1; cfg_idx = 3'd0; cfg_max = 3'd1; cfg_vec = 16'h0100;
      adj_valid = 1'b1; adj_idx = 3'd0; adj_up = 1'b1;
      @(posedge clk);
      #1;
      cfg_we = 1'b0; adj_valid = 1'b0;
      check(3'd2, 1'b1, 1'b1, 16'h0300, "R9 config beats adjust, R8 src1 vec0 skipped");

      // R10: configure with out-of-range index changes nothing
      drive(2'd1, 3'd6, 1'b0, 3'd0, 16'h0900, 6'b001111);
      check(3'd2, 1'b1, 1'b1, 16'h0300, "R10 out-of-range config ignored");

      // R1: reset in mid-run
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      check(3'd0, 1'b0, 1'b0, 16'h0, "R1 mid-run reset");
      @(negedge clk);
      rst_n = 1'b1;
      src_level = '0;
      @(posedge clk);
      #1;
      check(3'd0, 1'b0, 1'b0, 16'h0, "R1 idle after reset release");

      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule